// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital control core of a successive-approximation analog-to-digital converter. A host reaches it over a synchronous three-wire serial link made of an active-low chip select, a serial clock and a data-in line. The block drives a data-out line and a separate output enable, so that the pad can be tri-stated outside a transaction. The analog side supplies one comparator bit. In return, the block gives that side a trial code for the capacitor and resistor array, plus a channel selection for the input multiplexer.

A transaction begins when chip select goes low. The block samples data-in on rising clock edges and skips any zeros until it sees the first one, which is the start bit. It then shifts in a short channel-assignment word, whose length depends on the channel count. On the falling edge that follows the last assignment bit, the busy flag and the output enable rise. Data-out then drives a zero for one settling period. After that, each comparator decision is driven out on a falling edge, most significant bit first, and the next trial bit is presented. Once the busy flag drops, the block replays the result least significant bit first. The least significant bit is shared between the two streams, so the replay adds one bit fewer than the resolution. Data-out then stays low until chip select rises, which clears the block at once.

Top module: `sar_serial_seq`

## Requirements
- R1: While chip select is high, every register is cleared asynchronously: the output enable, busy and data-out read 0, and the trial code reads 0.
- R2: Data-in is sampled on rising clock edges. Zeros that arrive before the first one are ignored, and outputs stay as in R1 (enable low) for as long as no start bit has arrived.
- R3: The assignment word is WLEN bits long: 0, 2, 3 or 4 bits for 1, 2, 4 or 8 channels. It arrives first bit first, in this order: single-ended flag, odd/sign bit, then the select bits with the most significant first. Data-in has no effect on any output from the end of the word until chip select rises.
- R4: The channel index c is {select bits, odd bit}. If the single-ended flag is 1, the multiplexer outputs are positive = c, negative = 0 and common = 1. If the flag is 0, they are positive = c, negative = c XOR 1 and common = 0. In the one-channel variant the outputs are fixed at positive 0, negative 1, common 0.
- R5: On the falling edge after the last word bit (or after the start bit when WLEN is 0), busy and the output enable go high, data-out drives 0, and the trial code becomes 2^(RES-1).
- R6: On each of the next RES falling edges, data-out takes the comparator value sampled at that edge, which is also stored as the result bit, most significant first.
- R7: Busy stays high for exactly RES+1 falling edges and drops on the edge after the last decision.
- R8: Starting at the edge where busy drops, result bits 1 to RES-1 are driven one per falling edge. After that, data-out is held at 0 with the enable high until chip select rises.
- R9: If the comparator stays low for the whole conversion (negative input above positive), the result and both streams are all zeros.
- R10: Raising chip select in the middle of a conversion aborts it at once. A later high-to-low transition of chip select starts a full new transaction.
- R11: During the conversion, the trial code is made of the decided bits, plus a one at the bit under test, with all lower bits zero. After the last decision, the trial code equals the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select, clears the block while high |
| di | input | 1 | Serial data in |
| cmp_hi | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the data-out pad |
| busy | output | 1 | Conversion in progress |
| dac_code | output | RES | Trial code for the array |
| mux_pos | output | CW | Positive input channel index |
| mux_neg | output | CW | Negative input channel index (0 when common is used) |
| mux_com | output | 1 | Negative input is the common terminal |

## Verification
The most likely internal faults are a slip in the hunt or word counter, or a wrong bit index in the result register. A counter slip moves the rise of busy and the enable by whole clocks, so it is visible at the first compared edge after the start bit. An indexing fault corrupts either the trial code within one falling edge or a data-out bit in the first or second stream. Decode errors appear on the multiplexer outputs as soon as the word is complete. Reset faults show as soon as chip select rises, because the enable and the trial code must fall without waiting for a clock.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

   typedef enum logic [2:0] {
      ST_HUNT   = 3'd0,
      ST_ADDR   = 3'd1,
      ST_CONV   = 3'd2,
      ST_REPLAY = 3'd3,
      ST_TAIL   = 3'd4
   } sseq_state_e;

   // assignment word length for a given channel count
   function automatic int word_len(input int nch);
      return (nch == 1) ? 0 : ($clog2(nch) + 1);
   endfunction

   // width of a channel index
   function automatic int chan_w(input int nch);
      return (nch == 1) ? 1 : $clog2(nch);
   endfunction

endpackage

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
   import sseq_pkg::*;
#(
   parameter int RES  = 8,
   parameter int WLEN = 4,
   parameter int WR   = 4,
   parameter int SW   = 3,
   parameter int CNTW = 4
) (
   input  logic          sclk,
   input  logic          cs_n,
   input  logic          di_s,
   input  logic          cmp_hi,
   input  logic [RES-1:0] res,
   output logic          conv_en,
   output logic [SW-1:0] bit_idx,
   output logic [WR-1:0] word,
   output logic          busy,
   output logic          oe,
   output logic          dout
);

   localparam int WLAST = (WLEN > 0) ? WLEN - 1 : 0;

   sseq_state_e    state;
   logic [CNTW-1:0] cnt;
   logic [WR-1:0]   word_shift;
   logic [SW-1:0]   rep_idx;

   generate
      if (WLEN > 0) begin : g_word
         assign word_shift = {word[WR-2:0], di_s};
      end else begin : g_noword
         assign word_shift = '0;
      end
   endgenerate

   assign conv_en = (state == ST_CONV);
   assign rep_idx = cnt[SW-1:0];
   assign bit_idx = SW'(RES - 1) - cnt[SW-1:0];

   always_ff @(negedge sclk or posedge cs_n) begin
      if (cs_n) begin
         state <= ST_HUNT;
         cnt   <= '0;
         word  <= '0;
         busy  <= 1'b0;
         oe    <= 1'b0;
         dout  <= 1'b0;
      end else begin
         case (state)
            ST_HUNT: begin
               if (di_s) begin
                  if (WLEN == 0) begin
                     state <= ST_CONV;
                     cnt   <= '0;
                     busy  <= 1'b1;
                     oe    <= 1'b1;
                     dout  <= 1'b0;
                  end else begin
                     state <= ST_ADDR;
                     cnt   <= '0;
                  end
               end
            end
            ST_ADDR: begin
               word <= word_shift;
               if (cnt == CNTW'(WLAST)) begin
                  state <= ST_CONV;
                  cnt   <= '0;
                  busy  <= 1'b1;
                  oe    <= 1'b1;
                  dout  <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CONV: begin
               dout <= cmp_hi;
               if (cnt == CNTW'(RES - 1)) begin
                  state <= ST_REPLAY;
                  cnt   <= CNTW'(1);
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_REPLAY: begin
               busy <= 1'b0;
               dout <= res[rep_idx];
               if (cnt == CNTW'(RES - 1)) begin
                  state <= ST_TAIL;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               dout <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/sseq_sar.sv
module sseq_sar #(
   parameter int RES = 8,
   parameter int SW  = 3
) (
   input  logic           sclk,
   input  logic           cs_n,
   input  logic           conv_en,
   input  logic [SW-1:0]  bit_idx,
   input  logic           cmp_hi,
   output logic [RES-1:0] res,
   output logic [RES-1:0] dac_code
);

   logic [RES-1:0] trial;

   assign trial    = RES'(1) << bit_idx;
   assign dac_code = conv_en ? (res | trial) : res;

   always_ff @(negedge sclk or posedge cs_n) begin
      if (cs_n) begin
         res <= '0;
      end else if (conv_en) begin
         res[bit_idx] <= cmp_hi;
      end
   end

endmodule

// File: rtl/sseq_decode.sv
module sseq_decode #(
   parameter int NCH  = 8,
   parameter int WLEN = 4,
   parameter int WR   = 4,
   parameter int CW   = 3
) (
   input  logic [WR-1:0] word,
   output logic [CW-1:0] mux_pos,
   output logic [CW-1:0] mux_neg,
   output logic          mux_com
);

   logic [CW-1:0] chan;
   logic          sgl;

   generate
      if (NCH == 1) begin : g_fixed
         assign chan = '0;
         assign sgl  = 1'b0;
      end else if (WLEN == 2) begin : g_two
         assign chan = word[0];
         assign sgl  = word[1];
      end else begin : g_many
         assign chan = {word[WLEN-3:0], word[WLEN-2]};
         assign sgl  = word[WLEN-1];
      end
   endgenerate

   always_comb begin
      mux_pos = chan;
      if (sgl) begin
         mux_neg = '0;
         mux_com = 1'b1;
      end else begin
         mux_neg = chan ^ CW'(1);
         mux_com = 1'b0;
      end
   end

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
   import sseq_pkg::*;
#(
   parameter int NCH = 8,
   parameter int RES = 8,
   localparam int WLEN = word_len(NCH),
   localparam int WR   = (WLEN > 0) ? WLEN : 1,
   localparam int CW   = chan_w(NCH),
   localparam int SW   = $clog2(RES),
   localparam int CNTW = $clog2(RES + WLEN + 1)
) (
   input  logic           sclk,
   input  logic           cs_n,
   input  logic           di,
   input  logic           cmp_hi,
   output logic           dout,
   output logic           dout_oe,
   output logic           busy,
   output logic [RES-1:0] dac_code,
   output logic [CW-1:0]  mux_pos,
   output logic [CW-1:0]  mux_neg,
   output logic           mux_com
);

   initial begin
      if (!(NCH == 1 || NCH == 2 || NCH == 4 || NCH == 8))
         $fatal(1, "sar_serial_seq: NCH must be 1, 2, 4 or 8");
      if (RES < 2 || RES > 16)
         $fatal(1, "sar_serial_seq: RES must be within 2..16");
   end

   logic           di_s;
   logic           conv_en;
   logic [SW-1:0]  bit_idx;
   logic [WR-1:0]  word;
   logic [RES-1:0] res;

   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) di_s <= 1'b0;
      else      di_s <= di;
   end

   sseq_ctrl #(.RES(RES), .WLEN(WLEN), .WR(WR), .SW(SW), .CNTW(CNTW)) u_ctrl (
      .sclk    (sclk),
      .cs_n    (cs_n),
      .di_s    (di_s),
      .cmp_hi  (cmp_hi),
      .res     (res),
      .conv_en (conv_en),
      .bit_idx (bit_idx),
      .word    (word),
      .busy    (busy),
      .oe      (dout_oe),
      .dout    (dout)
   );

   sseq_sar #(.RES(RES), .SW(SW)) u_sar (
      .sclk     (sclk),
      .cs_n     (cs_n),
      .conv_en  (conv_en),
      .bit_idx  (bit_idx),
      .cmp_hi   (cmp_hi),
      .res      (res),
      .dac_code (dac_code)
   );

   sseq_decode #(.NCH(NCH), .WLEN(WLEN), .WR(WR), .CW(CW)) u_dec (
      .word    (word),
      .mux_pos (mux_pos),
      .mux_neg (mux_neg),
      .mux_com (mux_com)
   );

endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
   parameter int RES = 8
) (
   input logic           sclk,
   input logic           cs_n,
   input logic           busy,
   input logic           dout_oe,
   input logic           dout,
   input logic           cmp_hi,
   input logic [RES-1:0] dac_code
);

   logic [7:0] hi_cnt;

   always_ff @(negedge sclk or posedge cs_n) begin
      if (cs_n)      hi_cnt <= '0;
      else if (busy) hi_cnt <= hi_cnt + 1'b1;
      else           hi_cnt <= '0;
   end

   // R1: data-out is quiet whenever the pad is released
   p_quiet_off_r1: assert property (@(negedge sclk) disable iff (cs_n)
      !dout_oe |-> !dout);

   // R5: busy never stands without the output enable
   p_busy_oe_r5: assert property (@(negedge sclk) disable iff (cs_n)
      busy |-> dout_oe);

   // R5: the settle slot presents the top trial bit alone
   p_settle_trial_r5: assert property (@(negedge sclk) disable iff (cs_n)
      $rose(busy) |-> dac_code == (RES'(1) << (RES - 1)));

   // R6: each decision edge puts the comparator value on data-out
   p_decision_r6: assert property (@(negedge sclk) disable iff (cs_n)
      (busy && hi_cnt < 8'(RES)) |=> dout == $past(cmp_hi));

   // R7: busy lasts exactly RES+1 falling edges
   p_busy_len_r7: assert property (@(negedge sclk) disable iff (cs_n)
      $fell(busy) |-> hi_cnt == 8'(RES + 1));

   // R8: once enabled, the pad stays enabled until chip select rises
   p_oe_hold_r8: assert property (@(negedge sclk) disable iff (cs_n)
      dout_oe |=> dout_oe);

endmodule

bind sar_serial_seq sseq_chk #(.RES(RES)) u_chk (
   .sclk     (sclk),
   .cs_n     (cs_n),
   .busy     (busy),
   .dout_oe  (dout_oe),
   .dout     (dout),
   .cmp_hi   (cmp_hi),
   .dac_code (dac_code)
);

// File: tb/sar_serial_seq_test.sv
module sar_serial_seq_test;

   localparam int NCH  = 8;
   localparam int RES  = 8;
   localparam int WLEN = 4;
   localparam int CW   = 3;

   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic di   = 1'b0;
   logic cmp_hi;
   logic dout, dout_oe, busy, mux_com;
   logic [RES-1:0] dac_code;
   logic [CW-1:0]  mux_pos, mux_neg;
   int ain = 0;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   assign cmp_hi = (ain >= int'(dac_code));

   always #4 sclk = ~sclk;

   sar_serial_seq #(.NCH(NCH), .RES(RES)) uut (
      .sclk(sclk), .cs_n(cs_n), .di(di), .cmp_hi(cmp_hi),
      .dout(dout), .dout_oe(dout_oe), .busy(busy), .dac_code(dac_code),
      .mux_pos(mux_pos), .mux_neg(mux_neg), .mux_com(mux_com)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   task automatic chk_idle(input string tag);
      chk({tag, " enable"}, 32'(dout_oe), 0);
      chk({tag, " busy"}, 32'(busy), 0);
      chk({tag, " dout"}, 32'(dout), 0);
      chk({tag, " trial"}, 32'(dac_code), 0);
   endtask

   // one transaction; abort_at < 0 means no abort
   task automatic txn(input int lead, input logic [3:0] w, input int a,
                      input int abort_at, input logic fill);
      int r, k, len;
      logic eo, eb, ed;
      int edac, m;
      string tg;
      ain = a;
      r = (a < 0) ? 0 : (a > 255 ? 255 : a);
      k = lead + 1 + WLEN;
      len = k + 2 * RES + 3;
      @(negedge sclk); #1 cs_n = 1'b0;
      for (int j = 1; j <= len; j++) begin
         int i;
         i = j - 1;
         if (i < lead)              di = 1'b0;
         else if (i == lead)        di = 1'b1;
         else if (i <= lead + WLEN) di = w[WLEN - 1 - (i - lead - 1)];
         else                       di = fill ^ i[0];
         if (abort_at >= 0 && i == abort_at) begin
            cs_n = 1'b1; #1;
            chk_idle("R10 abort");
            return;
         end
         @(posedge sclk); #1;
         // expected state after falling edge number i
         if (i < k) begin
            eo = 0; eb = 0; ed = 0; edac = 0; tg = "R2";
         end else if (i == k) begin
            eo = 1; eb = 1; ed = 0; edac = 1 << (RES - 1); tg = "R5";
         end else if (i <= k + RES) begin
            m = i - k;
            eo = 1; eb = 1; ed = r[RES - m]; tg = "R6";
            edac = (m == RES) ? r :
                   ((r & ~((1 << (RES - m)) - 1)) | (1 << (RES - 1 - m)));
         end else if (i <= k + 2 * RES - 1) begin
            m = i - k - RES;
            eo = 1; eb = 0; ed = r[m]; edac = r; tg = "R8";
         end else begin
            eo = 1; eb = 0; ed = 0; edac = r; tg = "R8 tail";
         end
         chk({tg, " enable"}, 32'(dout_oe), 32'(eo));
         chk("R7 busy", 32'(busy), 32'(eb));
         chk({tg, " dout"}, 32'(dout), 32'(ed));
         chk("R11 trial code", 32'(dac_code), 32'(edac));
         @(negedge sclk); #1;
      end
      // R4: channel decode
      if (w[3]) begin
         chk("R4 pos", 32'(mux_pos), 32'({w[1:0], w[2]}));
         chk("R4 neg", 32'(mux_neg), 0);
         chk("R4 com", 32'(mux_com), 1);
      end else begin
         chk("R4 pos", 32'(mux_pos), 32'({w[1:0], w[2]}));
         chk("R4 neg", 32'(mux_neg), 32'({w[1:0], ~w[2]}));
         chk("R4 com", 32'(mux_com), 0);
      end
      cs_n = 1'b1; #1;
      chk_idle("R1 release");
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog expired: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #21;
      chk_idle("R1 reset");
      // R2: long hunt with no start bit keeps everything idle
      @(negedge sclk); #1 cs_n = 1'b0; di = 1'b0;
      for (int j = 0; j < 20; j++) begin
         @(posedge sclk); #1;
         chk("R2 hunt enable", 32'(dout_oe), 0);
         chk("R2 hunt busy", 32'(busy), 0);
         @(negedge sclk); #1;
      end
      cs_n = 1'b1; #1;
      // R3 R4: single-ended channel 4, trailing ones on data-in ignored
      txn(0, 4'b1010, 8'hA5, -1, 1'b1);
      // R3 R4: differential, odd set, pair 1 -> pos 3 neg 2
      txn(3, 4'b0101, 255, -1, 1'b0);
      // R9: negative input above positive gives zeros
      txn(5, 4'b1111, -5, -1, 1'b1);
      txn(1, 4'b0000, 1, -1, 1'b1);
      txn(2, 4'b0110, 8'h5A, -1, 1'b0);
      // R10: abort mid conversion then a fresh transaction
      txn(2, 4'b1001, 8'hC3, 2 + 1 + WLEN + 4, 1'b0);
      txn(0, 4'b1111, 8'h80, -1, 1'b1);
      txn(4, 4'b0011, 8'h7F, -1, 1'b0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule